// File: doc/BRIEF.md
# H-Bridge Control and Fault Supervisor

This block is the digital control core of a two-leg power bridge that drives a small DC motor. Two polarity inputs select, per leg, whether the high-side or the low-side switch conducts. Two disable inputs can take the whole bridge to high impedance. The block produces four gate enables, one per switch, and a pull-down enable for an active-low, open-drain status flag. Flags from the analog side arrive as digital inputs: short circuit, over-temperature, a "cooled below recovery level" indication, undervoltage, and a tri-state request from the current limiter.

A short-circuit or over-temperature event turns the bridge off and latches the status flag. The latch does not follow the condition away. It is released by a falling edge on the active-high disable input, by a rising edge on the active-high enable input, or by reset. Over-temperature is released only once the cooled indication is present. Undervoltage turns the bridge off and pulls the flag while it lasts, then recovers without any action. A current-limiter request turns the bridge off silently. Holding the enable low puts the block in sleep.

All external inputs pass through two-flop synchronizers. Every output is a register, so a change on an input pin shows at the outputs on the third rising clock edge. Each leg inserts a break-before-make gap of a parameterized number of clock cycles whenever it moves from one switch to the other.

Top module: `hb_supervisor`

## Requirements
- R1: An input change made between two clock edges reaches the outputs on the third following rising edge, and not earlier.
- R2: With enable_i high, disable_i low and no fault, undervoltage or limiter request, a polarity input at 1 turns on only that leg's high-side switch, and at 0 turns on only its low-side switch.
- R3: While disable_i is 1, all four switch enables are 0, and neither the status flag nor sleep is asserted because of it.
- R4: While enable_i is 0, all four switch enables are 0 and sleep_o is 1.
- R5: A short_i or hot_i pulse turns all four switch enables off and sets flag_pd_o to 1. Both stay that way after the pulse ends, whatever the polarity inputs do.
- R6: A latched fault is cleared by disable_i falling from 1 to 0 or by enable_i rising from 0 to 1. Neither disable_i rising nor enable_i falling clears it.
- R7: An over-temperature latch ignores the clearing edges of R6 while cool_i is 0, and accepts them once cool_i is 1.
- R8: While uv_i is 1, all switch enables are 0 and flag_pd_o is 1. When uv_i returns to 0, both recover with no toggle.
- R9: While ilim_off_i is 1, all four switch enables are 0 and flag_pd_o is not set by it.
- R10: When a leg moves from one switch to the other, both of its enables are 0 for exactly DEAD_CYC clock cycles. A leg that turns back on with the same switch it last used turns on at once.
- R11: Reset leaves all switch enables at 0, flag_pd_o at 0 and sleep_o at 1. Floating defaults apply: polarities high, disabled, not enabled.
- R12: The high-side and low-side enables of one leg are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pol_a_i | input | 1 | Leg A polarity: 1 high side, 0 low side |
| pol_b_i | input | 1 | Leg B polarity: 1 high side, 0 low side |
| disable_i | input | 1 | Active-high bridge disable |
| enable_i | input | 1 | Active-high enable; 0 means sleep |
| short_i | input | 1 | Short-circuit detected |
| hot_i | input | 1 | Over-temperature shutdown level reached |
| cool_i | input | 1 | Temperature below shutdown level minus hysteresis |
| uv_i | input | 1 | Supply undervoltage |
| ilim_off_i | input | 1 | Current-limiter tri-state request |
| hs_a_o | output | 1 | Leg A high-side enable |
| ls_a_o | output | 1 | Leg A low-side enable |
| hs_b_o | output | 1 | Leg B high-side enable |
| ls_b_o | output | 1 | Leg B low-side enable |
| flag_pd_o | output | 1 | Status flag pull-down enable (1 = flag low) |
| sleep_o | output | 1 | Sleep mode indication |

## Verification
The main function is tried with each polarity combination. Single-leg flips show that the dead-time gap is placed on the leg that changed and nowhere else. Disable, sleep, undervoltage and limiter requests are applied on their own. This separates the silent tri-state causes from those that pull the flag, and the self-recovering ones from the latched ones. Fault latches are followed through every edge direction on both disable inputs, and over-temperature is tried with and without the cooled indication, to tell clearing edges from non-clearing ones. A long pseudo-random stretch is then compared cycle by cycle against a behavioural model.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_drive_t;

  // Requested drive of one leg from the bridge permission and its polarity.
  function automatic leg_drive_t leg_request(input logic run, input logic pol);
    if (!run)      return LEG_OFF;
    else if (pol)  return LEG_HIGH;
    else           return LEG_LOW;
  endfunction

  // Clearing event: disable falling or enable rising.
  function automatic logic clear_edge(input logic dis_prev, input logic dis_now,
                                      input logic en_prev,  input logic en_now);
    return (dis_prev & ~dis_now) | (~en_prev & en_now);
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      stage1 <= d_i;
      q_o    <= stage1;
    end
  end
endmodule

// File: rtl/hb_fault.sv
module hb_fault
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_dis,
  input  logic s_en,
  input  logic s_short,
  input  logic s_hot,
  input  logic s_cool,
  output logic short_nx,
  output logic hot_nx,
  output logic short_held,
  output logic hot_held,
  output logic clr_evt
);
  logic dis_prev, en_prev;

  assign clr_evt  = clear_edge(dis_prev, s_dis, en_prev, s_en);
  assign short_nx = s_short | (short_held & ~clr_evt);
  assign hot_nx   = s_hot   | (hot_held & ~(clr_evt & s_cool));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_prev   <= 1'b1;
      en_prev    <= 1'b0;
      short_held <= 1'b0;
      hot_held   <= 1'b0;
    end else begin
      dis_prev   <= s_dis;
      en_prev    <= s_en;
      short_held <= short_nx;
      hot_held   <= hot_nx;
    end
  end

  // R5: a short latch survives until a clearing edge
  assert_short_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_held && !clr_evt) |=> short_held);

  // R7: over-temperature latch is kept while not cooled
  assert_hot_needs_cool_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_held && !s_cool) |=> hot_held);

  // R6: a rising disable never clears a latch on its own
  assert_no_clear_on_dis_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (short_held && s_dis && !dis_prev && en_prev == s_en) |=> short_held);
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  leg_drive_t want_i,
  output logic       hs_o,
  output logic       ls_o
);
  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
  localparam logic [CW-1:0] GAP_LAST = CW'(DEAD_CYC - 1);

  leg_drive_t    drv, last_side;
  logic [CW-1:0] gap_cnt;
  logic          gap_done;

  assign gap_done = (gap_cnt == GAP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv       <= LEG_OFF;
      last_side <= LEG_LOW;
      gap_cnt   <= GAP_LAST;
    end else if (drv != LEG_OFF) begin
      if (want_i != drv) begin
        last_side <= drv;
        drv       <= LEG_OFF;
        gap_cnt   <= '0;
      end
    end else if (want_i != LEG_OFF && (want_i == last_side || gap_done)) begin
      drv <= want_i;
    end else if (!gap_done) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign hs_o = (drv == LEG_HIGH);
  assign ls_o = (drv == LEG_LOW);

  // R12: no shoot-through
  assert_no_shoot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_o && ls_o));

  // R10: a switch turns on only after the opposite one was off
  assert_low_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_o) |-> !$past(hs_o));
  assert_high_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_o) |-> !$past(ls_o));
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_a_i,
  input  logic pol_b_i,
  input  logic disable_i,
  input  logic enable_i,
  input  logic short_i,
  input  logic hot_i,
  input  logic cool_i,
  input  logic uv_i,
  input  logic ilim_off_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o,
  output logic flag_pd_o,
  output logic sleep_o
);
  localparam int NLEG = 2;
  localparam int NIN  = 9;
  // bit order {ilim, uv, cool, hot, short, en, dis, pol_b, pol_a}
  localparam logic [NIN-1:0] IN_RST = 9'b0_0_1_0_0_0_1_1_1;

  logic [NIN-1:0] raw_in, syn_in;
  logic s_pol_a, s_pol_b, s_dis, s_en, s_short, s_hot, s_cool, s_uv, s_ilim;
  logic short_nx, hot_nx, short_held, hot_held, clr_evt;
  logic bridge_run, flag_r, sleep_r;
  logic [NLEG-1:0] pol_v, hs_v, ls_v;

  assign raw_in = {ilim_off_i, uv_i, cool_i, hot_i, short_i,
                   enable_i, disable_i, pol_b_i, pol_a_i};

  hb_sync #(.W(NIN), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_in));

  assign {s_ilim, s_uv, s_cool, s_hot, s_short,
          s_en, s_dis, s_pol_b, s_pol_a} = syn_in;

  hb_fault u_fault (
    .clk(clk), .rst_n(rst_n), .s_dis(s_dis), .s_en(s_en),
    .s_short(s_short), .s_hot(s_hot), .s_cool(s_cool),
    .short_nx(short_nx), .hot_nx(hot_nx),
    .short_held(short_held), .hot_held(hot_held), .clr_evt(clr_evt));

  assign bridge_run = s_en & ~s_dis & ~short_nx & ~hot_nx & ~s_uv & ~s_ilim;
  assign pol_v      = {s_pol_b, s_pol_a};

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .want_i(leg_request(bridge_run, pol_v[g])),
      .hs_o(hs_v[g]), .ls_o(ls_v[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_r  <= 1'b0;
      sleep_r <= 1'b1;
    end else begin
      flag_r  <= short_nx | hot_nx | s_uv;
      sleep_r <= ~s_en;
    end
  end

  assign hs_a_o    = hs_v[0];
  assign ls_a_o    = ls_v[0];
  assign hs_b_o    = hs_v[1];
  assign ls_b_o    = ls_v[1];
  assign flag_pd_o = flag_r;
  assign sleep_o   = sleep_r;

  // R5: any held fault means flag low and bridge off
  assert_fault_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_held || hot_held) |-> (flag_pd_o && !(|hs_v) && !(|ls_v)));

  // R4: sleep request takes all switches off
  assert_sleep_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> (sleep_o && !(|hs_v) && !(|ls_v)));

  // R8: undervoltage pulls the flag and tri-states
  assert_uv_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_uv |=> (flag_pd_o && !(|hs_v) && !(|ls_v)));

  // R9: limiter request turns every switch off
  assert_ilim_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ilim |=> (!(|hs_v) && !(|ls_v)));
endmodule

// File: tb/test_hb_supervisor.sv
module test_hb_supervisor;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_a = 1'b1, pol_b = 1'b1, dis = 1'b1, en = 1'b0;
  logic sc = 1'b0, hot = 1'b0, cool = 1'b1, uv = 1'b0, ilim = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b, flag_pd, sleep;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  string phase = "R11";

  always #10 clk = ~clk;

  hb_supervisor #(.DEAD_CYC(DEAD)) i_hb_supervisor (
    .clk(clk), .rst_n(rst_n), .pol_a_i(pol_a), .pol_b_i(pol_b),
    .disable_i(dis), .enable_i(en), .short_i(sc), .hot_i(hot),
    .cool_i(cool), .uv_i(uv), .ilim_off_i(ilim),
    .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b),
    .flag_pd_o(flag_pd), .sleep_o(sleep));

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s {hsA,lsA,hsB,lsB,flag,sleep} actual=%b expected=%b at %0t",
               tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] outs();
    return {hs_a, ls_a, hs_b, ls_b, flag_pd, sleep};
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [8:0] m_q1, m_q2;   // {ilim,uv,cool,hot,short,en,dis,pol_b,pol_a}
  bit m_short, m_hot, m_pdis, m_pen, m_flag, m_sleep;
  int m_drv[2], m_cnt[2], m_last[2];  // drive: 0 off, 1 high, 2 low

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q1 = 9'b0_0_1_0_0_0_1_1_1; m_q2 = m_q1;
      m_short = 0; m_hot = 0; m_pdis = 1; m_pen = 0; m_flag = 0; m_sleep = 1;
      for (int l = 0; l < 2; l++) begin m_drv[l] = 0; m_cnt[l] = DEAD - 1; m_last[l] = 2; end
    end else begin
      bit clr, run, ns, nh;
      int want;
      clr = (m_pdis && !m_q2[2]) || (!m_pen && m_q2[3]);
      ns  = m_q2[4] || (m_short && !clr);
      nh  = m_q2[5] || (m_hot && !(clr && m_q2[6]));
      run = m_q2[3] && !m_q2[2] && !ns && !nh && !m_q2[7] && !m_q2[8];
      for (int l = 0; l < 2; l++) begin
        want = !run ? 0 : (m_q2[l] ? 1 : 2);
        if (m_drv[l] != 0) begin
          if (want != m_drv[l]) begin m_last[l] = m_drv[l]; m_drv[l] = 0; m_cnt[l] = 0; end
        end else if (want != 0 && (want == m_last[l] || m_cnt[l] >= DEAD - 1)) m_drv[l] = want;
        else if (m_cnt[l] < DEAD - 1) m_cnt[l]++;
      end
      m_flag = ns || nh || m_q2[7];
      m_sleep = !m_q2[3];
      m_short = ns; m_hot = nh; m_pdis = m_q2[2]; m_pen = m_q2[3];
      m_q2 = m_q1;
      m_q1 = {ilim, uv, cool, hot, sc, en, dis, pol_b, pol_a};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk({"model ", phase},
          outs(), {m_drv[0] == 1, m_drv[0] == 2, m_drv[1] == 1, m_drv[1] == 2, m_flag, m_sleep});
      if ((hs_a && ls_a) || (hs_b && ls_b)) chk("R12 shoot-through", 6'b1, 6'b0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_dis();
    dis = 1'b1; step(3); dis = 1'b0; step(3);
  endtask

  initial begin
    step(3);
    chk("R11 reset state", outs(), 6'b000001);
    rst_n = 1'b1;
    step(2);
    chk("R11 defaults after reset", outs(), 6'b000001);

    phase = "R2";
    en = 1; dis = 0; pol_a = 1; pol_b = 0;
    step(2); chk("R1 no change before third edge", outs(), 6'b000001);
    step(1); chk("R1 R2 drive on third edge", outs(), 6'b100100);

    phase = "R10";
    pol_a = 0;
    step(5); chk("R10 leg A in gap", outs(), 6'b000100);
    step(1); chk("R10 leg A low after gap", outs(), 6'b010100);
    pol_b = 1;
    step(6); chk("R2 R10 leg B high", outs(), 6'b011000);

    phase = "R3";
    dis = 1; step(3); chk("R3 disabled off without flag", outs(), 6'b000000);
    dis = 0; step(3); chk("R10 same side resumes at once", outs(), 6'b011000);

    phase = "R4";
    en = 0; step(3); chk("R4 sleep", outs(), 6'b000001);
    en = 1; step(3); chk("R4 wake", outs(), 6'b011000);

    phase = "R5";
    sc = 1; step(2); sc = 0; step(3);
    chk("R5 short latched", outs(), 6'b000010);
    pol_a = 1; step(3); chk("R5 polarity ignored while latched", outs(), 6'b000010);
    pol_a = 0; step(2);
    phase = "R6";
    dis = 1; step(4); chk("R6 disable rise keeps latch", outs(), 6'b000010);
    dis = 0; step(3); chk("R6 disable fall clears", outs(), 6'b011000);
    sc = 1; step(2); sc = 0; step(3);
    en = 0; step(4); chk("R6 enable fall keeps latch", outs(), 6'b000011);
    en = 1; step(3); chk("R6 enable rise clears", outs(), 6'b011000);

    phase = "R7";
    cool = 0; hot = 1; step(2); hot = 0; step(3);
    chk("R5 over-temperature latched", outs(), 6'b000010);
    toggle_dis(); chk("R7 not cooled keeps latch", outs(), 6'b000010);
    cool = 1; step(3);
    toggle_dis(); chk("R7 cooled clears", outs(), 6'b011000);

    phase = "R8";
    uv = 1; step(3); chk("R8 undervoltage flag", outs(), 6'b000010);
    uv = 0; step(3); chk("R8 auto recovery", outs(), 6'b011000);

    phase = "R9";
    ilim = 1; step(3); chk("R9 limiter off no flag", outs(), 6'b000000);
    ilim = 0; step(3); chk("R9 limiter release", outs(), 6'b011000);

    phase = "R10";
    pol_a = 1; pol_b = 0;
    step(5); chk("R10 both legs in gap", outs(), 6'b000000);
    step(1); chk("R10 both legs swapped", outs(), 6'b100100);

    phase = "R12";
    for (int i = 0; i < 600; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      pol_a = r[0]; pol_b = r[1];
      if (r[9:6] == 0) dis = ~dis;
      if (r[9:6] == 1) en = ~en;
      sc = (r[9:5] == 5'd7);
      hot = (r[9:5] == 5'd9);
      cool = r[4] | r[3];
      uv = (r[9:6] == 4'd5);
      ilim = (r[9:6] == 4'd6);
      step(1 + int'(r[2]));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule